// File: doc/BRIEF.md
# Serial Slave Hold Front End

This block sits at the pin side of a serial-flash-style SPI slave. It samples chip select, serial clock, an active-low pause pin and serial data in with a fast free-running system clock. It turns serial-clock edges into a gated shift strobe that feeds an internal 8-bit receive shifter. While the pause is in force, the shifter, its bit counter and the outgoing data all stay frozen, and the serial-out enable is dropped.

A pause takes effect only at points where the serial clock is low. A change of the pause pin while the clock is high waits for the next clock-low point, and this applies to both entry and exit. Deselecting the device during a pause resets the serial logic. After that, the pause pin must go high before a new pause can begin, so reselecting with the pin still low resumes normal shifting.

The block echoes each received byte on serial data out during the following byte. Data out is enabled once the first byte of a frame is complete. A busy flag from the internal write engine passes through untouched, so a pause never disturbs it.

Top module: `spi_hold_front`

## Requirements
- R1: While chip select is high, the bit counter and receive shifter are cleared, data-out enable is low and no byte is reported. A partial byte cut short by deselection is discarded.
- R2: While selected and not paused, serial data in is shifted MSB-first on each serial-clock rising edge. A one-cycle `rx_valid` pulse with the assembled byte on `rx_byte` follows every eighth such edge.
- R3: Data-out enable is high only while selected, not paused, and after the frame's first complete byte. After byte k completes, the next eight serial-clock falling edges present byte k on `miso`, MSB first.
- R4: With chip select low and serial clock low, driving `hold_n` low pauses the block: `miso_oe` drops. Driving `hold_n` high again with the clock low resumes it.
- R5: A `hold_n` edge made while the serial clock is high has no effect until the clock next goes low. This applies to both entry and exit.
- R6: While paused, serial clock and data-in activity produce no shift strobe, no received bit and no change to the outgoing bit sequence.
- R7: Deselecting while paused resets the serial logic. A pause is then not entered again until `hold_n` has been high. While `hold_n` stays low after reselection, bytes are received normally.
- R8: `busy_out` equals `busy_in` at all times, paused or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock, at least 4x serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock pin |
| hold_n | input | 1 | Pause request pin, active low |
| mosi | input | 1 | Serial data in |
| busy_in | input | 1 | Busy flag from the internal write engine |
| busy_out | output | 1 | Busy flag passed through |
| shift_en | output | 1 | One-cycle strobe per accepted serial-clock rising edge |
| rx_valid | output | 1 | Pulse when a full byte is received |
| rx_byte | output | DW | Last received byte |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Serial data out enable (low means high impedance) |

## Verification
The bench builds the block with its default parameters: an 8-bit shifter and a 2-stage synchronizer. The serial clock runs at one sixteenth of the system clock. That gives each pin change eight system cycles to pass through the synchronizer before the bench samples, so every pause edge can be placed on a chosen side of a serial-clock level. At the 8-bit width, the echo of one byte during the next can be compared bit by bit with multi-byte random frames. It also lets a pause land both mid-byte and across a byte boundary's falling edge.

// File: rtl/spi_hold_front.sv
module spi_hold_front #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          hold_n,
  input  logic          mosi,
  input  logic          busy_in,
  output logic          busy_out,
  output logic          shift_en,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte,
  output logic          miso,
  output logic          miso_oe
);
  localparam int CW = $clog2(DW);

  logic [SYNC-1:0] cs_p, sck_p, hld_p, di_p;
  logic            sck_q;
  logic            cs_s, sck_s, hold_req, din;
  logic            sck_rise, sck_fall, tx_step, last_bit;
  logic            held, locked, byte_seen, tx_pend;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   sr, tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      hld_p <= '1;
      di_p  <= '0;
      sck_q <= 1'b0;
    end else begin
      cs_p  <= {cs_p[SYNC-2:0], cs_n};
      sck_p <= {sck_p[SYNC-2:0], sclk};
      hld_p <= {hld_p[SYNC-2:0], hold_n};
      di_p  <= {di_p[SYNC-2:0], mosi};
      sck_q <= sck_p[SYNC-1];
    end
  end

  assign cs_s     = cs_p[SYNC-1];
  assign sck_s    = sck_p[SYNC-1];
  assign hold_req = ~hld_p[SYNC-1];
  assign din      = di_p[SYNC-1];
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign shift_en = ~cs_s & ~held & sck_rise;
  assign tx_step  = ~cs_s & ~held & sck_fall;
  assign last_bit = (cnt == CW'(DW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      locked <= 1'b0;
    end else if (cs_s) begin
      held   <= 1'b0;
      locked <= (locked | held) & hold_req;
    end else begin
      locked <= locked & hold_req;
      if (!sck_s) held <= hold_req & ~locked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sr        <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      byte_seen <= 1'b0;
      tx_pend   <= 1'b0;
    end else if (cs_s) begin
      cnt       <= '0;
      sr        <= '0;
      tx_sr     <= '0;
      rx_valid  <= 1'b0;
      byte_seen <= 1'b0;
      tx_pend   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (shift_en) begin
        sr  <= {sr[DW-2:0], din};
        cnt <= last_bit ? '0 : CW'(cnt + 1'b1);
        if (last_bit) begin
          rx_valid  <= 1'b1;
          rx_byte   <= {sr[DW-2:0], din};
          byte_seen <= 1'b1;
          tx_pend   <= 1'b1;
        end
      end
      if (tx_step) begin
        if (tx_pend) begin
          tx_sr   <= rx_byte;
          tx_pend <= 1'b0;
        end else begin
          tx_sr <= tx_sr << 1;
        end
      end
    end
  end

  assign miso     = tx_sr[DW-1];
  assign miso_oe  = ~cs_s & ~held & byte_seen;
  assign busy_out = busy_in;
endmodule

// File: rtl/spi_hold_front_chk.sv
module spi_hold_front_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          sck_s,
  input logic          held,
  input logic          locked,
  input logic          rx_valid,
  input logic [CW-1:0] cnt,
  input logic [DW-1:0] sr
);
  AST_ENTRY_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s)); // R5
  AST_EXIT_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> (!$past(sck_s) || $past(cs_s))); // R5
  AST_FROZEN_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(cnt) && $stable(sr))); // R6
  AST_LOCK_BLOCKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !held); // R7
  AST_VALID_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cnt == '0)); // R2
  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0 && !held && !rx_valid)); // R1
endmodule

bind spi_hold_front spi_hold_front_chk #(.DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .held(held),
  .locked(locked), .rx_valid(rx_valid), .cnt(cnt), .sr(sr)
);

// File: tb/spi_hold_front_tb_top.sv
module spi_hold_front_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sclk, hold_n, mosi, busy_in;
  logic busy_out, shift_en, rx_valid, miso, miso_oe;
  logic [7:0] rx_byte;

  spi_hold_front #(.DW(8), .SYNC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
    .mosi(mosi), .busy_in(busy_in), .busy_out(busy_out), .shift_en(shift_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(miso), .miso_oe(miso_oe)
  );

  int checks = 0, fails = 0, n_shift = 0;
  bit done = 1'b0;
  logic [7:0] got[$];

  always @(negedge clk) if (rst_n === 1'b1) begin
    if (rx_valid) got.push_back(rx_byte);
    if (shift_en) n_shift++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rand_byte();
    return 8'($urandom);
  endfunction

  function automatic logic echo_bit(logic [7:0] prev, int i);
    return prev[i];
  endfunction

  task automatic send_bits(logic [7:0] b, int hi, int lo, logic chk, logic [7:0] prev);
    for (int i = hi; i >= lo; i--) begin
      mosi = b[i];
      step(8);
      if (chk) begin
        check("R3 miso", miso, echo_bit(prev, i));
        check("R3 oe", miso_oe, 1);
      end
      sclk = 1'b1;
      step(8);
      sclk = 1'b0;
    end
  endtask

  task automatic expect_rx(logic [7:0] e, string req);
    step(8);
    if (got.size() == 0) begin
      checks++; fails++;
      $display("FAIL %s actual=none expected=%0h", req, e);
    end else check(req, got.pop_front(), e);
  endtask

  initial begin
    logic [7:0] a, b, c, e, prev;
    int s0, nb;
    void'($urandom(32'd17));
    rst_n = 0; cs_n = 1; sclk = 0; hold_n = 1; mosi = 0; busy_in = 0;
    step(5); rst_n = 1; step(8);
    check("R1 oe after reset", miso_oe, 0);
    check("R1 no strobe", n_shift, 0);
    check("R1 no byte", got.size(), 0);

    for (int f = 0; f < 6; f++) begin
      cs_n = 0; step(8);
      check("R3 oe before first byte", miso_oe, 0);
      nb = 1 + int'($urandom % 4);
      prev = 8'h00;
      for (int k = 0; k < nb; k++) begin
        b = rand_byte();
        send_bits(b, 7, 0, k > 0, prev);
        expect_rx(b, "R2 rx");
        if (k == 0) check("R3 oe after first byte", miso_oe, 1);
        prev = b;
      end
      cs_n = 1; step(8);
      check("R1 oe deselected", miso_oe, 0);
    end

    // pause entered and left with serial clock low
    cs_n = 0; step(8);
    a = 8'hA5; send_bits(a, 7, 0, 0, 8'h00); expect_rx(a, "R2 rx");
    b = 8'h3C; send_bits(b, 7, 5, 1, a);
    hold_n = 0; busy_in = 1; step(8);
    check("R4 oe in hold", miso_oe, 0);
    check("R8 busy high", busy_out, 1);
    s0 = n_shift;
    repeat (3) begin
      mosi = ~mosi; sclk = 1; step(8); sclk = 0; step(8);
    end
    check("R6 no strobe", n_shift, s0);
    check("R6 no byte", got.size(), 0);
    busy_in = 0; step(1);
    check("R8 busy low", busy_out, 0);
    hold_n = 1; step(8);
    check("R4 oe after exit", miso_oe, 1);
    send_bits(b, 4, 0, 1, a);
    expect_rx(b, "R6 frozen byte");

    // pause edges made with serial clock high
    c = 8'h96; send_bits(c, 7, 6, 1, b);
    mosi = c[5]; step(8);
    check("R3 miso", miso, b[5]);
    sclk = 1; step(8);
    hold_n = 0; step(8);
    check("R5 entry deferred", miso_oe, 1);
    sclk = 0; step(8);
    check("R5 entry at low", miso_oe, 0);
    s0 = n_shift;
    sclk = 1; mosi = ~mosi; step(8); sclk = 0; step(8);
    sclk = 1; step(8);
    hold_n = 1; step(8);
    check("R5 exit deferred", miso_oe, 0);
    sclk = 0; step(8);
    check("R5 exit at low", miso_oe, 1);
    check("R6 no strobe", n_shift, s0);
    send_bits(c, 4, 0, 1, b);
    expect_rx(c, "R5 byte intact");

    // deselect while paused
    send_bits(8'hFF, 7, 5, 0, 8'h00);
    hold_n = 0; step(8);
    check("R7 paused", miso_oe, 0);
    cs_n = 1; step(8);
    cs_n = 0; step(8);
    e = 8'h4B; send_bits(e, 7, 0, 0, 8'h00);
    expect_rx(e, "R7 R1 rx after reselect");
    check("R7 not paused", miso_oe, 1);
    hold_n = 1; step(8);
    hold_n = 0; step(8);
    check("R7 pause again", miso_oe, 0);
    hold_n = 1; step(8);
    cs_n = 1; step(8);
    check("R1 no stray bytes", got.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule